// File: doc/BRIEF.md
# Planar Host Memory Mapper

This block sits between a host byte bus and four byte-wide display memory planes. On every host access it turns the host byte address into one address that all planes share. It also produces a set of per-plane write enables, or a single per-plane read enable. Run-time register bits select one of three mappings:

- **Packed four-way:** each host byte lands in one plane, chosen by the low address pair.
- **Interleaved even/odd:** even and odd host bytes go to different plane pairs.
- **Plain planar:** every host byte reaches the same offset in every enabled plane.

Software programs the block through an index/data port pair. A write with the select low loads an index. A write with the select high stores the data into the register that the index names. Two registers exist: the plane write mask and the memory mapping control. Read data comes back from the single plane the current mapping selects. The plane memories are assumed to return data combinationally.

Top module: `vga_plane_mapper`

## Requirements
- R1: After reset the plane mask is 4'b1111, the packed bit is 0 and the interleave-off bit is 0, so the interleaved even/odd mapping is active.
- R2: A port write with `cfg_sel`=0 loads the index. A write with `cfg_sel`=1 stores data into the indexed register: index 0x02 takes the plane mask from data bits [3:0]; index 0x04 takes the packed bit from data bit 3 and the interleave-off bit from data bit 2. The new values govern host accesses from the next cycle on.
- R3: The packed bit wins over everything else. Otherwise an interleave-off bit of 0 selects even/odd. Otherwise the mapping is plain planar.
- R4: Packed write: the plane enabled is the one numbered by `host_addr[1:0]`, ANDed with the mask. The plane address is `host_addr >> 2`.
- R5: Packed read: the plane numbered by `host_addr[1:0]` is read, and `host_rdata` is that plane's byte (plane k occupies `plane_rdata[8k+7:8k]`).
- R6: Even/odd write: an even address enables planes 0 and 2, and an odd address enables planes 1 and 3, each ANDed with the mask. The plane address is `host_addr >> 1`.
- R7: Even/odd read: the plane read is `{rd_map_sel[1], host_addr[0]}`. The plane address is `host_addr >> 1`.
- R8: Planar write: the write enables equal the mask. The plane address equals `host_addr`.
- R9: Planar read: the plane read is `rd_map_sel`. The plane address equals `host_addr`.
- R10: With `host_req` low, all write and read enables are 0. A read never asserts a write enable, and a write never asserts a read enable.
- R11: A data write to any index other than 0x02 or 0x04 changes neither the mask nor the mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register port write strobe |
| cfg_sel | input | 1 | 0: write index, 1: write data |
| cfg_wdata | input | 8 | Register port write data |
| host_req | input | 1 | Host access valid this cycle |
| host_we | input | 1 | 1: write, 0: read |
| host_addr | input | HADDR_W | Host byte address |
| rd_map_sel | input | 2 | Read plane choice for planar and even/odd reads |
| plane_rdata | input | 4*DATA_W | Read bytes of all four planes |
| plane_addr | output | HADDR_W | Address shared by all planes |
| plane_wen | output | 4 | Per-plane write enables |
| plane_ren | output | 4 | Per-plane read enable (one-hot on a read) |
| host_rdata | output | DATA_W | Byte returned to the host |

## Verification
A register port write and a host access can fall in the same cycle. The host access must then use the old mask and mapping, and the new values apply only from the following cycle. The random stream issues port writes and host accesses independently of each other, so they coincide often. A bench model judges each access against the register values as they stood before that cycle's edge, and the model updates only after the comparison.

// File: rtl/vpm_pkg.sv
package vpm_pkg;
   typedef enum logic [1:0] {
      MAP_PLANAR  = 2'd0,
      MAP_ODDEVEN = 2'd1,
      MAP_PACKED  = 2'd2
   } map_mode_e;

   localparam int NPLANES     = 4;
   localparam int PSEL_W      = 2;
   localparam logic [7:0] IDX_MASK = 8'h02;
   localparam logic [7:0] IDX_MODE = 8'h04;
   localparam int BIT_PACKED  = 3;
   localparam int BIT_OE_OFF  = 2;
endpackage

// File: rtl/vpm_seq_regs.sv
module vpm_seq_regs
   import vpm_pkg::*;
#(
   parameter int CFG_W = 8
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               cfg_sel,
   input  logic [CFG_W-1:0]   cfg_wdata,
   output logic [NPLANES-1:0] map_mask,
   output map_mode_e          mode
);
   logic [CFG_W-1:0] idx_q;
   logic             packed_q;
   logic             oe_off_q;

   initial assert (CFG_W >= 8) else $error("CFG_W must hold an index");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         map_mask <= '1;
         packed_q <= 1'b0;
         oe_off_q <= 1'b0;
      end else if (cfg_we) begin
         if (!cfg_sel) begin
            idx_q <= cfg_wdata;
         end else if (idx_q == CFG_W'(IDX_MASK)) begin
            map_mask <= cfg_wdata[NPLANES-1:0];
         end else if (idx_q == CFG_W'(IDX_MODE)) begin
            packed_q <= cfg_wdata[BIT_PACKED];
            oe_off_q <= cfg_wdata[BIT_OE_OFF];
         end
      end
   end

   always_comb begin
      if (packed_q)       mode = MAP_PACKED;
      else if (!oe_off_q) mode = MAP_ODDEVEN;
      else                mode = MAP_PLANAR;
   end

   a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel && idx_q == CFG_W'(IDX_MASK)) |=> map_mask == $past(cfg_wdata[NPLANES-1:0]));

   a_r11_other_index_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel && idx_q != CFG_W'(IDX_MASK) && idx_q != CFG_W'(IDX_MODE))
      |=> ($stable(map_mask) && $stable(mode)));
endmodule

// File: rtl/vpm_addr_map.sv
module vpm_addr_map
   import vpm_pkg::*;
#(
   parameter int HADDR_W = 16
)(
   input  logic               clk,
   input  logic               rst_n,
   input  map_mode_e          mode,
   input  logic [NPLANES-1:0] map_mask,
   input  logic               host_req,
   input  logic               host_we,
   input  logic [HADDR_W-1:0] host_addr,
   input  logic [PSEL_W-1:0]  rd_map_sel,
   output logic [HADDR_W-1:0] plane_addr,
   output logic [NPLANES-1:0] plane_wen,
   output logic [NPLANES-1:0] plane_ren,
   output logic [PSEL_W-1:0]  rd_plane
);
   initial assert (HADDR_W >= 3) else $error("HADDR_W too small");

   logic [NPLANES-1:0] sel_planes;
   logic               do_wr, do_rd;

   assign do_wr = host_req &&  host_we;
   assign do_rd = host_req && !host_we;

   always_comb begin
      case (mode)
         MAP_PACKED: begin
            plane_addr = host_addr >> 2;
            rd_plane   = host_addr[1:0];
         end
         MAP_ODDEVEN: begin
            plane_addr = host_addr >> 1;
            rd_plane   = {rd_map_sel[1], host_addr[0]};
         end
         default: begin
            plane_addr = host_addr;
            rd_plane   = rd_map_sel;
         end
      endcase
   end

   for (genvar p = 0; p < NPLANES; p++) begin : g_plane
      always_comb begin
         case (mode)
            MAP_PACKED:  sel_planes[p] = (host_addr[1:0] == PSEL_W'(p));
            MAP_ODDEVEN: sel_planes[p] = (host_addr[0] == p[0]);
            default:     sel_planes[p] = 1'b1;
         endcase
      end
      assign plane_wen[p] = do_wr && sel_planes[p] && map_mask[p];
      assign plane_ren[p] = do_rd && (rd_plane == PSEL_W'(p));
   end

   a_r4_packed_single: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MAP_PACKED) |-> $onehot0(plane_wen));

   a_r6_oddeven_parity: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MAP_ODDEVEN) |-> ((plane_wen & (host_addr[0] ? 4'b0101 : 4'b1010)) == 4'b0000));

   a_r8_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (plane_wen & ~map_mask) == '0);

   a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !host_req |-> (plane_wen == '0 && plane_ren == '0));

   a_r10_read_one_plane: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !host_we) |-> ($countones(plane_ren) == 1 && plane_wen == '0));
endmodule

// File: rtl/vpm_rd_mux.sv
module vpm_rd_mux
   import vpm_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic [NPLANES*DATA_W-1:0] plane_rdata,
   input  logic [PSEL_W-1:0]         rd_plane,
   output logic [DATA_W-1:0]         host_rdata
);
   logic [NPLANES-1:0][DATA_W-1:0] masked;

   for (genvar p = 0; p < NPLANES; p++) begin : g_gate
      assign masked[p] = (rd_plane == PSEL_W'(p)) ? plane_rdata[p*DATA_W +: DATA_W] : '0;
   end

   always_comb begin
      host_rdata = '0;
      for (int p = 0; p < NPLANES; p++) host_rdata |= masked[p];
   end
endmodule

// File: rtl/vga_plane_mapper.sv
module vga_plane_mapper
   import vpm_pkg::*;
#(
   parameter int HADDR_W = 16,
   parameter int DATA_W  = 8
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic                      cfg_sel,
   input  logic [7:0]                cfg_wdata,
   input  logic                      host_req,
   input  logic                      host_we,
   input  logic [HADDR_W-1:0]        host_addr,
   input  logic [1:0]                rd_map_sel,
   input  logic [4*DATA_W-1:0]       plane_rdata,
   output logic [HADDR_W-1:0]        plane_addr,
   output logic [3:0]                plane_wen,
   output logic [3:0]                plane_ren,
   output logic [DATA_W-1:0]         host_rdata
);
   initial assert (DATA_W >= 1) else $error("DATA_W must be positive");

   logic [NPLANES-1:0] map_mask;
   map_mode_e          mode;
   logic [PSEL_W-1:0]  rd_plane;

   vpm_seq_regs #(.CFG_W(8)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .map_mask(map_mask), .mode(mode)
   );

   vpm_addr_map #(.HADDR_W(HADDR_W)) u_map (
      .clk(clk), .rst_n(rst_n), .mode(mode), .map_mask(map_mask),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .rd_map_sel(rd_map_sel), .plane_addr(plane_addr),
      .plane_wen(plane_wen), .plane_ren(plane_ren), .rd_plane(rd_plane)
   );

   vpm_rd_mux #(.DATA_W(DATA_W)) u_rmux (
      .plane_rdata(plane_rdata), .rd_plane(rd_plane), .host_rdata(host_rdata)
   );
endmodule

// File: tb/sim_vga_plane_mapper.sv
module sim_vga_plane_mapper;
   localparam int AW = 16;
   localparam int DW = 8;

   logic clk = 0, rst_n = 0;
   logic cfg_we = 0, cfg_sel = 0;
   logic [7:0] cfg_wdata = 0;
   logic host_req = 0, host_we = 0;
   logic [AW-1:0] host_addr = 0;
   logic [1:0] rd_map_sel = 0;
   logic [4*DW-1:0] plane_rdata = 0;
   logic [AW-1:0] plane_addr;
   logic [3:0] plane_wen, plane_ren;
   logic [DW-1:0] host_rdata;

   int n_chk = 0, n_bad = 0;
   logic [7:0] m_idx;
   logic [3:0] m_mask;
   logic m_pk, m_oeoff;

   always #5 clk = ~clk;

   vga_plane_mapper #(.HADDR_W(AW), .DATA_W(DW)) u0 (.*);

   // 0 planar, 1 even/odd, 2 packed (R3 priority)
   function automatic int ex_mode();
      if (m_pk) return 2;
      if (!m_oeoff) return 1;
      return 0;
   endfunction

   function automatic string ex_tag(bit we);
      case (ex_mode())
         2: return we ? "R4" : "R5";
         1: return we ? "R6" : "R7";
         default: return we ? "R8" : "R9";
      endcase
   endfunction

   function automatic logic [AW-1:0] ex_addr(logic [AW-1:0] a);
      case (ex_mode())
         2: return a >> 2;
         1: return a >> 1;
         default: return a;
      endcase
   endfunction

   function automatic logic [1:0] ex_rplane(logic [AW-1:0] a, logic [1:0] s);
      case (ex_mode())
         2: return a[1:0];
         1: return {s[1], a[0]};
         default: return s;
      endcase
   endfunction

   function automatic logic [3:0] ex_wen(logic req, logic we, logic [AW-1:0] a);
      logic [3:0] sel;
      if (!(req && we)) return 4'b0000;
      case (ex_mode())
         2: sel = 4'b0001 << a[1:0];
         1: sel = a[0] ? 4'b1010 : 4'b0101;
         default: sel = 4'b1111;
      endcase
      return sel & m_mask;
   endfunction

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // one cycle: drive at negedge, compare before posedge, then advance model
   task automatic cycle(logic cwe, logic csel, logic [7:0] cd,
                        logic rq, logic we, logic [AW-1:0] a, logic [1:0] s,
                        string tag_over);
      logic [3:0] ew, er;
      logic [1:0] rp;
      string t;
      @(negedge clk);
      cfg_we = cwe; cfg_sel = csel; cfg_wdata = cd;
      host_req = rq; host_we = we; host_addr = a; rd_map_sel = s;
      plane_rdata = $urandom;
      #1;
      t = (tag_over != "") ? tag_over : ex_tag(we);
      ew = ex_wen(rq, we, a);
      rp = ex_rplane(a, s);
      er = (rq && !we) ? (4'b0001 << rp) : 4'b0000;
      check(rq ? t : "R10", "wen", 32'(plane_wen), 32'(ew));
      check(rq ? t : "R10", "ren", 32'(plane_ren), 32'(er));
      check(t, "addr", 32'(plane_addr), 32'(ex_addr(a)));
      if (rq && !we) check(t, "rdata", 32'(host_rdata), 32'(plane_rdata[rp*DW +: DW]));
      if (cwe) begin
         if (!csel) m_idx = cd;
         else if (m_idx == 8'h02) m_mask = cd[3:0];
         else if (m_idx == 8'h04) begin m_pk = cd[3]; m_oeoff = cd[2]; end
      end
   endtask

   task automatic reg_wr(logic [7:0] idx, logic [7:0] d);
      cycle(1, 0, idx, 0, 0, 0, 0, "R2");
      cycle(1, 1, d, 0, 0, 0, 0, "R2");
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      m_idx = 0; m_mask = 4'hF; m_pk = 0; m_oeoff = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R1: reset state gives even/odd with full mask
      cycle(0, 0, 0, 1, 1, 16'h0003, 0, "R1");
      cycle(0, 0, 0, 1, 1, 16'h0010, 0, "R1");
      // R2 + R4: packed, mask 4'b1011 hides plane 2
      reg_wr(8'h04, 8'h08);
      reg_wr(8'h02, 8'h0B);
      cycle(0, 0, 0, 1, 1, 16'h0006, 0, "R4");
      cycle(0, 0, 0, 1, 1, 16'h0007, 0, "R4");
      cycle(0, 0, 0, 1, 0, 16'h0006, 2'd1, "R5");
      // R3: packed wins even with interleave-off set
      reg_wr(8'h04, 8'h0C);
      cycle(0, 0, 0, 1, 1, 16'hFFFD, 0, "R3");
      // R11: unknown index write is ignored
      reg_wr(8'h05, 8'h00);
      cycle(0, 0, 0, 1, 1, 16'h0001, 0, "R11");
      reg_wr(8'h00, 8'hFF);
      cycle(0, 0, 0, 1, 1, 16'h0002, 0, "R11");
      // planar: R8 and R9
      reg_wr(8'h04, 8'h04);
      cycle(0, 0, 0, 1, 1, 16'h1235, 0, "R8");
      cycle(0, 0, 0, 1, 0, 16'h1235, 2'd2, "R9");
      // R2 same-cycle: mode write and host access coincide, old mode applies
      cycle(1, 0, 8'h04, 0, 0, 0, 0, "R2");
      cycle(1, 1, 8'h08, 1, 1, 16'h0009, 0, "R2");
      cycle(0, 0, 0, 1, 1, 16'h0009, 0, "R2");
      // R7: even/odd read
      reg_wr(8'h04, 8'h00);
      cycle(0, 0, 0, 1, 0, 16'h0021, 2'd2, "R7");
      // random mix
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r;
         logic [7:0] d;
         r = $urandom;
         d = $urandom;
         if (r[3:0] == 0) d = (r[5:4] == 0) ? 8'h02 : (r[5:4] == 1) ? 8'h04 : d;
         cycle(r[3:0] < 3, r[6], d, r[7] | r[8], r[9], $urandom, r[11:10], "");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule